// File: doc/BRIEF.md
# Serial Programming Row-Erase Sequencer

This block is the programmer side of a two-wire in-circuit serial programming link. It has one clock output and one data line, which it drives through an output enable. Its job is to erase a target's flash one 1024-byte row at a time. Each word on the link is a transfer of 20 bits: a 4-bit command code of all zeros, followed by a 16-bit instruction payload. Bits go out least significant first. Data changes as the link clock rises, and the target samples it when the clock falls.

For each row, the sequencer sends a fixed series of words:
- a write-enable word;
- the words that set the table pointer to the row address;
- an erase-select word and a start-write word;
- a no-operation word, whose fourth clock pulse is stretched.

The target runs the erase while that fourth pulse is held high. The pulse stays high for the hold-high time, and the clock then stays low for the discharge time before any further bit moves. The block then steps the pointer by 1024 and repeats the series until it has erased the requested number of rows.

A host pulses the start input with a nonzero row count. Busy stays high for the whole run. Done pulses for one cycle at the moment busy falls. The row count and both hold times are captured when a run begins.

Top module: `serprog_row_eraser`

## Requirements
- R1: While reset is asserted and after it is released, the link clock, the data enable, busy and done are all low until a start is accepted.
- R2: Every transfer is 20 link clock pulses: four command bits of value 0, then a 16-bit payload sent LSB first. The data line changes only together with a rising link clock. Each ordinary high and low phase lasts DIV system cycles.
- R3: For row 0 the payloads are, in order, 84A6, 6AF8, 6AF7, 6AF6, 88A6, 82A6 and 0000.
- R4: For row n (n ≥ 1) the byte address is A = n×1024. The payloads are, in order: 84A6, 0E followed by A[23:16], 6EF8, 0E followed by A[15:8], 6EF7, 0E followed by A[7:0], 6EF6, 88A6, 82A6 and 0000.
- R5: In the final no-operation transfer of each row, the fourth link clock pulse is high for the hold-high count of system cycles. The clock then stays low for the hold-low count before the fifth pulse. A count of 0 is treated as 1. The fourth pulse of every other transfer is ordinary.
- R6: A run erases exactly row_count_i rows, starting at row 0, so it sends 7 + 10×(rows−1) transfers.
- R7: Busy rises in the cycle after an accepted start and stays high until the last transfer ends. Done is high for exactly one cycle, in the cycle in which busy first reads low.
- R8: A start that arrives while busy has no effect, and a change on row_count_i during a run has no effect on the number of rows.
- R9: A start with row_count_i equal to 0 is ignored: busy, done and the link stay idle.
- R10: The data enable is high exactly while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled only while idle |
| row_count_i | input | ROW_W | Number of rows to erase |
| hold_hi_i | input | TW | Stretched-pulse high time in system cycles |
| hold_lo_i | input | TW | Discharge low time in system cycles |
| link_clk_o | output | 1 | Link clock |
| link_dat_o | output | 1 | Link data value |
| link_dat_oe_o | output | 1 | Link data drive enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Some behaviours are checked by the assertions on every cycle. These are: data moving only on a rising link clock, a quiet link and a released data line while idle, done being a single cycle that coincides with the fall of busy, and busy rising only after an accepted start with a nonzero count.

Other behaviours only the bench's scenarios can show, because they depend on decoding whole transfers. These are the actual payload words and pointer bytes of each row, the number of rows erased, the stretched high and discharge lengths, and the fact that a second start or a changed row count during a run does not alter the run.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  localparam int CMD_BITS   = 4;
  localparam int WORD_BITS  = 16;
  localparam int FRAME_BITS = CMD_BITS + WORD_BITS;
  localparam int PTR_W      = 24;
  localparam int ROW_SHIFT  = 10;
  localparam int STEP_W     = 4;

  typedef enum logic [1:0] {SH_IDLE, SH_HIGH, SH_LOW} sh_state_t;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_WAIT} sq_state_t;

  // Index of the final (stretched) word in a row's series.
  function automatic logic [STEP_W-1:0] last_step(input logic first_row);
    return first_row ? STEP_W'(6) : STEP_W'(9);
  endfunction

  // Instruction word for a given position in a row's series.
  function automatic logic [WORD_BITS-1:0] payload_of(
    input logic              first_row,
    input logic [STEP_W-1:0] step,
    input logic [PTR_W-1:0]  addr
  );
    logic [WORD_BITS-1:0] w;
    w = 16'h0000;
    if (first_row) begin
      case (step)
        4'd0: w = 16'h84A6;
        4'd1: w = 16'h6AF8;
        4'd2: w = 16'h6AF7;
        4'd3: w = 16'h6AF6;
        4'd4: w = 16'h88A6;
        4'd5: w = 16'h82A6;
        default: w = 16'h0000;
      endcase
    end else begin
      case (step)
        4'd0: w = 16'h84A6;
        4'd1: w = {8'h0E, addr[23:16]};
        4'd2: w = 16'h6EF8;
        4'd3: w = {8'h0E, addr[15:8]};
        4'd4: w = 16'h6EF7;
        4'd5: w = {8'h0E, addr[7:0]};
        4'd6: w = 16'h6EF6;
        4'd7: w = 16'h88A6;
        4'd8: w = 16'h82A6;
        default: w = 16'h0000;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/serprog_shifter.sv
module serprog_shifter
  import serprog_pkg::*;
#(
  parameter int DIV = 2,
  parameter int TW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  stretch_i,
  input  logic [TW-1:0]         hold_hi_i,
  input  logic [TW-1:0]         hold_lo_i,
  output logic                  link_clk_o,
  output logic                  link_dat_o,
  output logic                  frame_done_o
);

  localparam int            IDX_W    = $clog2(FRAME_BITS);
  localparam logic [TW-1:0] HALF     = TW'(DIV - 1);
  localparam logic [IDX_W-1:0] STR_IDX  = IDX_W'(CMD_BITS - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(CMD_BITS - 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  sh_state_t             st_q, st_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [TW-1:0]         cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  str_q, str_d;
  logic                  clk_q, clk_d;
  logic                  dat_q, dat_d;
  logic                  fd_q, fd_d;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    str_d = str_q;
    clk_d = clk_q;
    dat_d = dat_q;
    fd_d  = 1'b0;
    case (st_q)
      SH_IDLE: begin
        if (load_i) begin
          st_d  = SH_HIGH;
          idx_d = '0;
          str_d = stretch_i;
          clk_d = 1'b1;
          dat_d = frame_i[0];
          sh_d  = frame_i >> 1;
          cnt_d = HALF;
        end
      end
      SH_HIGH: begin
        if (cnt_q == '0) begin
          st_d  = SH_LOW;
          clk_d = 1'b0;
          cnt_d = (str_q && idx_q == STR_IDX) ? hold_lo_i - TW'(1) : HALF;
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      SH_LOW: begin
        if (cnt_q == '0) begin
          if (idx_q == LAST_IDX) begin
            st_d = SH_IDLE;
            fd_d = 1'b1;
          end else begin
            st_d  = SH_HIGH;
            idx_d = idx_q + IDX_W'(1);
            clk_d = 1'b1;
            dat_d = sh_q[0];
            sh_d  = sh_q >> 1;
            cnt_d = (str_q && idx_q == PRE_IDX) ? hold_hi_i - TW'(1) : HALF;
          end
        end else begin
          cnt_d = cnt_q - TW'(1);
        end
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      idx_q <= '0;
      cnt_q <= '0;
      sh_q  <= '0;
      str_q <= 1'b0;
      clk_q <= 1'b0;
      dat_q <= 1'b0;
      fd_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      str_q <= str_d;
      clk_q <= clk_d;
      dat_q <= dat_d;
      fd_q  <= fd_d;
    end
  end

  assign link_clk_o   = clk_q;
  assign link_dat_o   = dat_q;
  assign frame_done_o = fd_q;

endmodule

// File: rtl/serprog_ctrl.sv
module serprog_ctrl
  import serprog_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int TW    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [ROW_W-1:0]      rows_i,
  input  logic [TW-1:0]         hold_hi_i,
  input  logic [TW-1:0]         hold_lo_i,
  input  logic                  frame_done_i,
  output logic                  load_o,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  stretch_o,
  output logic [TW-1:0]         hold_hi_o,
  output logic [TW-1:0]         hold_lo_o,
  output logic                  busy_o,
  output logic                  done_o
);

  sq_state_t         st_q, st_d;
  logic [ROW_W-1:0]  rows_q, rows_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [TW-1:0]     hi_q, hi_d;
  logic [TW-1:0]     lo_q, lo_d;
  logic              busy_q, busy_d;
  logic              done_q, done_d;

  logic              first_row;
  logic              at_last_step;
  logic              at_last_row;
  logic [PTR_W-1:0]  row_addr;

  assign first_row    = (row_q == '0);
  assign at_last_step = (step_q == last_step(first_row));
  assign at_last_row  = (row_q == rows_q - ROW_W'(1));
  assign row_addr     = PTR_W'({row_q, {ROW_SHIFT{1'b0}}});

  always_comb begin
    st_d   = st_q;
    rows_d = rows_q;
    row_d  = row_q;
    step_d = step_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    busy_d = busy_q;
    done_d = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start_i && rows_i != '0) begin
          st_d   = SQ_LOAD;
          rows_d = rows_i;
          row_d  = '0;
          step_d = '0;
          hi_d   = (hold_hi_i == '0) ? TW'(1) : hold_hi_i;
          lo_d   = (hold_lo_i == '0) ? TW'(1) : hold_lo_i;
          busy_d = 1'b1;
        end
      end
      SQ_LOAD: st_d = SQ_WAIT;
      SQ_WAIT: begin
        if (frame_done_i) begin
          if (!at_last_step) begin
            step_d = step_q + STEP_W'(1);
            st_d   = SQ_LOAD;
          end else if (at_last_row) begin
            st_d   = SQ_IDLE;
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            row_d  = row_q + ROW_W'(1);
            step_d = '0;
            st_d   = SQ_LOAD;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      rows_q <= '0;
      row_q  <= '0;
      step_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rows_q <= rows_d;
      row_q  <= row_d;
      step_q <= step_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign load_o    = (st_q == SQ_LOAD);
  assign frame_o   = {payload_of(first_row, step_q, row_addr), {CMD_BITS{1'b0}}};
  assign stretch_o = at_last_step;
  assign hold_hi_o = hi_q;
  assign hold_lo_o = lo_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

endmodule

// File: rtl/serprog_row_eraser.sv
module serprog_row_eraser
  import serprog_pkg::*;
#(
  parameter int DIV   = 2,
  parameter int ROW_W = 8,
  parameter int TW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [ROW_W-1:0] row_count_i,
  input  logic [TW-1:0]    hold_hi_i,
  input  logic [TW-1:0]    hold_lo_i,
  output logic             link_clk_o,
  output logic             link_dat_o,
  output logic             link_dat_oe_o,
  output logic             busy_o,
  output logic             done_o
);

  logic [1:0]            rst_sync_q;
  logic                  rst_int_n;
  logic                  load;
  logic [FRAME_BITS-1:0] frame;
  logic                  stretch;
  logic [TW-1:0]         hold_hi;
  logic [TW-1:0]         hold_lo;
  logic                  frame_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  serprog_ctrl #(.ROW_W(ROW_W), .TW(TW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (start_i),
    .rows_i       (row_count_i),
    .hold_hi_i    (hold_hi_i),
    .hold_lo_i    (hold_lo_i),
    .frame_done_i (frame_done),
    .load_o       (load),
    .frame_o      (frame),
    .stretch_o    (stretch),
    .hold_hi_o    (hold_hi),
    .hold_lo_o    (hold_lo),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  serprog_shifter #(.DIV(DIV), .TW(TW)) u_shift (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .load_i       (load),
    .frame_i      (frame),
    .stretch_i    (stretch),
    .hold_hi_i    (hold_hi),
    .hold_lo_i    (hold_lo),
    .link_clk_o   (link_clk_o),
    .link_dat_o   (link_dat_o),
    .frame_done_o (frame_done)
  );

  assign link_dat_oe_o = busy_o;

endmodule

// File: rtl/serprog_row_eraser_chk.sv
module serprog_row_eraser_chk #(
  parameter int ROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [ROW_W-1:0] row_count_i,
  input logic             link_clk_o,
  input logic             link_dat_o,
  input logic             link_dat_oe_o,
  input logic             busy_o,
  input logic             done_o
);

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R7

  AST_LINK_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!link_clk_o && !link_dat_oe_o)); // R10

  AST_DRIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> link_dat_oe_o); // R10

  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_dat_o) |-> $rose(link_clk_o)); // R2

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && $past(row_count_i) != '0)); // R9

endmodule

bind serprog_row_eraser serprog_row_eraser_chk #(.ROW_W(ROW_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .row_count_i   (row_count_i),
  .link_clk_o    (link_clk_o),
  .link_dat_o    (link_dat_o),
  .link_dat_oe_o (link_dat_oe_o),
  .busy_o        (busy_o),
  .done_o        (done_o)
);

// File: tb/sim_serprog_row_eraser.sv
`timescale 1ns/1ps
module sim_serprog_row_eraser;
  localparam int DIV = 2, ROW_W = 8, TW = 16, NV = 3;
  // stimulus table: rows, hold high, hold low, restart-while-busy
  localparam int V_ROWS [NV] = '{1, 3, 2};
  localparam int V_HI   [NV] = '{5, 1, 0};
  localparam int V_LO   [NV] = '{3, 1, 7};
  localparam int V_RST  [NV] = '{0, 1, 0};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, clk_l, dat_l, oe_l, busy, done;
  logic [ROW_W-1:0] rows;
  logic [TW-1:0] hhi, hlo;

  serprog_row_eraser #(.DIV(DIV), .ROW_W(ROW_W), .TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .row_count_i(rows),
    .hold_hi_i(hhi), .hold_lo_i(hlo), .link_clk_o(clk_l), .link_dat_o(dat_l),
    .link_dat_oe_o(oe_l), .busy_o(busy), .done_o(done));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // link decoder
  logic mon_clr = 1'b0;
  logic [15:0] cap_word [64];
  logic [3:0]  cap_cmd  [64];
  int cap_hi3 [64];
  int cap_lo3 [64];
  int nfr, done_cnt, bitn, hi_cnt, lo_cnt, cur_hi3, cur_lo3, bad_hi;
  logic [19:0] bits;
  logic prev_clk;
  longint cyc = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "R7", "watchdog expired", cyc, 190000);
      summary();
    end
    if (mon_clr || !rst_n) begin
      nfr = 0; done_cnt = 0; bitn = 0; hi_cnt = 0; lo_cnt = 0;
      bad_hi = 0; prev_clk = 1'b0; bits = '0; cur_hi3 = 0; cur_lo3 = 0;
    end else begin
      if (done) done_cnt++;
      if (clk_l && !prev_clk) begin
        if (bitn == 4) cur_lo3 = lo_cnt;
        hi_cnt = 1;
      end else if (clk_l) begin
        hi_cnt++;
      end else if (prev_clk) begin
        bits[bitn] = dat_l;
        if (bitn == 3) cur_hi3 = hi_cnt;
        else if (hi_cnt != DIV) bad_hi++;
        lo_cnt = 1;
        bitn++;
        if (bitn == 20) begin
          if (nfr < 64) begin
            cap_word[nfr] = bits[19:4];
            cap_cmd[nfr]  = bits[3:0];
            cap_hi3[nfr]  = cur_hi3;
            cap_lo3[nfr]  = cur_lo3;
          end
          nfr++;
          bitn = 0;
        end
      end else begin
        lo_cnt++;
      end
      prev_clk = clk_l;
    end
  end

  function automatic logic [15:0] exp_word(input int row, input int k);
    logic [23:0] a;
    a = 24'(row * 1024);
    if (row == 0) begin
      case (k)
        0: return 16'h84A6; 1: return 16'h6AF8; 2: return 16'h6AF7;
        3: return 16'h6AF6; 4: return 16'h88A6; 5: return 16'h82A6;
        default: return 16'h0000;
      endcase
    end
    case (k)
      0: return 16'h84A6; 1: return {8'h0E, a[23:16]}; 2: return 16'h6EF8;
      3: return {8'h0E, a[15:8]}; 4: return 16'h6EF7; 5: return {8'h0E, a[7:0]};
      6: return 16'h6EF6; 7: return 16'h88A6; 8: return 16'h82A6;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic run_vec(input int nrows, input int hi, input int lo, input int restart);
    int exp_fr, f, hie, loe;
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    rows = ROW_W'(nrows); hhi = TW'(hi); hlo = TW'(lo); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", busy, 1);
    if (restart != 0) begin
      repeat (100) @(negedge clk);
      rows = ROW_W'(5); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 20000 && done_cnt == 0; i++) @(negedge clk);
    chk(done_cnt == 1, "R7", "done seen", done_cnt, 1);
    repeat (60) @(negedge clk);
    chk(done_cnt == 1, "R7", "single done", done_cnt, 1);
    chk(busy == 1'b0 && oe_l == 1'b0, "R10", "idle after run", {busy, oe_l}, 0);
    exp_fr = 7 + 10 * (nrows - 1);
    chk(nfr == exp_fr, restart != 0 ? "R8" : "R6", "transfer count", nfr, exp_fr);
    chk(bad_hi == 0, "R2", "ordinary high phases", bad_hi, 0);
    hie = (hi == 0) ? 1 : hi;
    loe = (lo == 0) ? 1 : lo;
    f = 0;
    for (int r = 0; r < nrows; r++) begin
      int nk;
      nk = (r == 0) ? 7 : 10;
      for (int k = 0; k < nk; k++) begin
        if (f < nfr && f < 64) begin
          chk(cap_word[f] == exp_word(r, k), r == 0 ? "R3" : "R4", "payload",
              cap_word[f], exp_word(r, k));
          chk(cap_cmd[f] == 4'h0, "R2", "command bits", cap_cmd[f], 0);
          if (k == nk - 1) begin
            chk(cap_hi3[f] == hie, "R5", "stretched high", cap_hi3[f], hie);
            chk(cap_lo3[f] == loe, "R5", "discharge low", cap_lo3[f], loe);
          end else begin
            chk(cap_hi3[f] == DIV, "R5", "unstretched 4th pulse", cap_hi3[f], DIV);
          end
        end
        f++;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rows = '0; hhi = '0; hlo = '0;
    repeat (4) @(negedge clk);
    chk({clk_l, oe_l, busy, done} == 4'b0, "R1", "outputs in reset", {clk_l, oe_l, busy, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({clk_l, oe_l, busy, done} == 4'b0, "R1", "outputs after reset", {clk_l, oe_l, busy, done}, 0);

    for (int v = 0; v < NV; v++) run_vec(V_ROWS[v], V_HI[v], V_LO[v], V_RST[v]);

    // R9: zero row count
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    rows = '0; hhi = TW'(4); hlo = TW'(4); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b0, "R9", "busy on zero count", busy, 0);
    repeat (60) @(negedge clk);
    chk(nfr == 0 && done_cnt == 0, "R9", "no activity on zero count", nfr + done_cnt, 0);
    chk(clk_l == 1'b0 && oe_l == 1'b0, "R9", "link idle on zero count", {clk_l, oe_l}, 0);

    summary();
  end
endmodule